// File: doc/BRIEF.md
# System Clock Strobe Divider with Peripheral Enables

This block runs entirely on one fast system clock and does not create any derived clocks. Instead it produces single-cycle enable strobes. The first stage divides the system clock into a main-bus strobe. Two peripheral-bus domains each divide that main-bus strobe further. Each peripheral-bus domain also has a timer-kernel strobe. When the domain divider is 1, the timer strobe is the same as the bus strobe. When the domain divider is larger than 1, the timer strobe runs at twice the bus rate.

A small register interface holds the divider codes and one enable bit per peripheral. Each peripheral receives one gated strobe, taken from a source chosen by a parameter. Register accesses to a peripheral's window are forwarded only while its enable bit is set. A disabled peripheral sees no write, and a read of it returns zero.

A new divider code is picked up only when the affected divider reaches its terminal count. As a result, a strobe interval is never shortened by reprogramming.

Top module: `clkstb_gen`

## Requirements
- R1: The main-bus code is 4 bits. Codes 0 to 7 divide by 1. Codes 8 to 15 divide by 2, 4, 8, 16, 64, 128, 256 and 512 respectively. The main-bus strobe is high for one system cycle out of every divisor cycles.
- R2: Each peripheral-bus code is 3 bits. Codes 0 to 3 divide by 1. Codes 4 to 7 divide by 2, 4, 8 and 16. One peripheral-bus strobe is produced per divisor main-bus strobes.
- R3: A peripheral-bus strobe is high only in a cycle where the main-bus strobe is also high.
- R4: With a domain divider of 1, that domain's timer strobe is identical to its bus strobe.
- R5: With a domain divider greater than 1, the timer strobe fires twice per bus period. One firing coincides with every bus strobe and the other falls at the period midpoint. With a divider of 2, the timer strobe therefore equals the main-bus strobe.
- R6: A changed divider code takes effect only after the affected divider's next terminal count. The interval that is in progress finishes with the old period.
- R7: All enable bits reset to 0. The strobe for peripheral i is its source strobe ANDed with enable bit i. The default sources are: peripheral 0 on the main bus, peripheral 1 on bus 0, peripheral 2 on timer 1, and peripheral 3 on bus 1.
- R8: While enable bit i is 0, a write to address 2+i raises no peripheral write strobe, a read raises no peripheral read strobe, and the read data is 0. While the bit is 1, all three pass through in the same cycle.
- R9: The register map is as follows. Address 0 holds the divider codes: main bus in bits [3:0], bus 0 in [6:4], bus 1 in [10:8]. Address 1 holds the enable bits in [NP-1:0]. Both reset to 0, and reads return them combinationally in the same cycle.
- R10: After reset, every divider starts at divide-by-1, so the main-bus strobe is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write request |
| bus_rd_i | input | 1 | Register read request |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid in the cycle of the read |
| ahb_stb_o | output | 1 | Main-bus strobe |
| apb_stb_o | output | 2 | Peripheral-bus strobes, one per domain |
| tmr_stb_o | output | 2 | Timer-kernel strobes, one per domain |
| per_stb_o | output | NP | Gated strobe for each peripheral |
| per_wr_o | output | NP | Forwarded write strobe for each peripheral |
| per_rd_o | output | NP | Forwarded read strobe for each peripheral |
| per_wdata_o | output | DW | Write data to the peripherals |
| per_rdata_i | input | NP*DW | Read data from the peripherals, packed |

## Verification
All strobes are decoded from divider state in the same cycle, so they depend only on register contents. The bench therefore compares every strobe against its model at each falling edge.

A divider-code write lands at the rising edge that ends the write cycle. It is then applied at the next terminal count of the divider. The model lets both steps happen on exactly the same edges, and an explicit interval measurement confirms the one-period delay.

Register reads and peripheral forwarding are combinational, so they are sampled shortly after the request is driven, within the same cycle. Rate checks count strobes over a 1024-cycle window that starts right after a strobe. This makes each expected count an exact quotient.

// File: rtl/clkstb_pkg.sv
package clkstb_pkg;

  localparam int AHB_CODE_W = 4;
  localparam int APB_CODE_W = 3;
  localparam int AHB_SH_W   = 4;   // shift up to 9
  localparam int APB_SH_W   = 3;   // shift up to 4
  localparam int AHB_CNT_W  = 9;   // counts up to 511
  localparam int APB_CNT_W  = 4;   // counts up to 15
  localparam int SRC_W      = 3;

  // strobe source selectors for a peripheral
  localparam logic [SRC_W-1:0] SRC_AHB  = 3'd0;
  localparam logic [SRC_W-1:0] SRC_APB0 = 3'd1;
  localparam logic [SRC_W-1:0] SRC_APB1 = 3'd2;
  localparam logic [SRC_W-1:0] SRC_TMR0 = 3'd3;
  localparam logic [SRC_W-1:0] SRC_TMR1 = 3'd4;

  // main-bus code -> log2 of divisor (8..11 -> 1..4, 12..15 -> 6..9)
  function automatic logic [AHB_SH_W-1:0] ahb_shift(input logic [AHB_CODE_W-1:0] code);
    logic [AHB_SH_W-1:0] sh;
    if (!code[3]) sh = '0;
    else          sh = {1'b0, code[2:0]} + (code[2] ? 4'd2 : 4'd1);
    return sh;
  endfunction

  // peripheral-bus code -> log2 of divisor (4..7 -> 1..4)
  function automatic logic [APB_SH_W-1:0] apb_shift(input logic [APB_CODE_W-1:0] code);
    logic [APB_SH_W-1:0] sh;
    if (!code[2]) sh = '0;
    else          sh = {1'b0, code[1:0]} + 3'd1;
    return sh;
  endfunction

endpackage

// File: rtl/clkstb_div.sv
// Power-of-two strobe divider advancing on tick_i; period change applied at terminal count.
module clkstb_div #(
  parameter int CW = 9,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [SW-1:0] sh_req_i,
  output logic          stb_o,
  output logic          mid_o
);
  localparam int SPW = CW + 1;

  logic [CW-1:0]  cnt_q, cnt_d;
  logic [SW-1:0]  sh_q, sh_d;
  logic [SPW-1:0] span;
  logic [CW-1:0]  last, half;
  logic           term;

  always_comb begin
    span  = SPW'(1) << sh_q;
    last  = span[CW-1:0] - CW'(1);
    half  = last >> 1;
    term  = (cnt_q == last);
    stb_o = tick_i & term;
    mid_o = tick_i & ((cnt_q & half) == half);
    cnt_d = cnt_q + CW'(1);
    sh_d  = sh_q;
    if (term) begin
      cnt_d = '0;
      sh_d  = sh_req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

endmodule

// File: rtl/clkstb_regs.sv
// Divider code and enable registers plus per-peripheral access gating.
module clkstb_regs
  import clkstb_pkg::*;
#(
  parameter int NP = 4,
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [NP*DW-1:0]      per_rdata_i,
  output logic [AHB_CODE_W-1:0] ahb_code_o,
  output logic [APB_CODE_W-1:0] apb0_code_o,
  output logic [APB_CODE_W-1:0] apb1_code_o,
  output logic [NP-1:0]         en_o,
  output logic [NP-1:0]         per_wr_o,
  output logic [NP-1:0]         per_rd_o
);
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_EN  = AW'(1);
  localparam int            PBASE = 2;

  logic [AHB_CODE_W-1:0] ahb_q, ahb_d;
  logic [APB_CODE_W-1:0] apb0_q, apb0_d, apb1_q, apb1_d;
  logic [NP-1:0]         en_q, en_d;
  logic                  cfg_we, en_we;
  logic [NP-1:0]         sel;

  for (genvar i = 0; i < NP; i++) begin : g_sel
    assign sel[i]      = (addr_i == AW'(PBASE + i));
    assign per_wr_o[i] = wr_i & sel[i] & en_q[i];
    assign per_rd_o[i] = rd_i & sel[i] & en_q[i];
  end

  always_comb begin
    cfg_we = wr_i & (addr_i == A_CFG);
    en_we  = wr_i & (addr_i == A_EN);
    ahb_d  = wdata_i[3:0];
    apb0_d = wdata_i[6:4];
    apb1_d = wdata_i[10:8];
    en_d   = wdata_i[NP-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ahb_q  <= '0;
      apb0_q <= '0;
      apb1_q <= '0;
    end else if (cfg_we) begin
      ahb_q  <= ahb_d;
      apb0_q <= apb0_d;
      apb1_q <= apb1_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == A_CFG)     rdata_o = DW'({apb1_q, 1'b0, apb0_q, ahb_q});
      else if (addr_i == A_EN) rdata_o = DW'(en_q);
      else begin
        for (int i = 0; i < NP; i++) begin
          if (sel[i] && en_q[i]) rdata_o = per_rdata_i[i*DW +: DW];
        end
      end
    end
  end

  assign ahb_code_o  = ahb_q;
  assign apb0_code_o = apb0_q;
  assign apb1_code_o = apb1_q;
  assign en_o        = en_q;

endmodule

// File: rtl/clkstb_gen.sv
module clkstb_gen
  import clkstb_pkg::*;
#(
  parameter int                NP      = 4,
  parameter int                DW      = 16,
  parameter int                AW      = 4,
  parameter logic [NP*3-1:0]   PER_SRC = {3'd2, 3'd4, 3'd1, 3'd0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             ahb_stb_o,
  output logic [1:0]       apb_stb_o,
  output logic [1:0]       tmr_stb_o,
  output logic [NP-1:0]    per_stb_o,
  output logic [NP-1:0]    per_wr_o,
  output logic [NP-1:0]    per_rd_o,
  output logic [DW-1:0]    per_wdata_o,
  input  logic [NP*DW-1:0] per_rdata_i
);
  localparam int NDOM = 2;

  logic [AHB_CODE_W-1:0] ahb_code;
  logic [APB_CODE_W-1:0] apb_code [NDOM];
  logic [NP-1:0]         en_w;
  logic                  ahb_stb, ahb_mid_unused;
  logic [NDOM-1:0]       apb_stb, tmr_stb;

  clkstb_regs #(.NP(NP), .DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (bus_wr_i),
    .rd_i        (bus_rd_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .per_rdata_i (per_rdata_i),
    .ahb_code_o  (ahb_code),
    .apb0_code_o (apb_code[0]),
    .apb1_code_o (apb_code[1]),
    .en_o        (en_w),
    .per_wr_o    (per_wr_o),
    .per_rd_o    (per_rd_o)
  );

  clkstb_div #(.CW(AHB_CNT_W), .SW(AHB_SH_W)) u_ahb_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (1'b1),
    .sh_req_i (ahb_shift(ahb_code)),
    .stb_o    (ahb_stb),
    .mid_o    (ahb_mid_unused)
  );

  for (genvar k = 0; k < NDOM; k++) begin : g_apb
    clkstb_div #(.CW(APB_CNT_W), .SW(APB_SH_W)) u_apb_div (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (ahb_stb),
      .sh_req_i (apb_shift(apb_code[k])),
      .stb_o    (apb_stb[k]),
      .mid_o    (tmr_stb[k])
    );
  end

  for (genvar i = 0; i < NP; i++) begin : g_per
    localparam logic [SRC_W-1:0] SRC = PER_SRC[i*SRC_W +: SRC_W];
    logic raw;
    if (SRC == SRC_AHB)       begin : g_s assign raw = ahb_stb;    end
    else if (SRC == SRC_APB0) begin : g_s assign raw = apb_stb[0]; end
    else if (SRC == SRC_APB1) begin : g_s assign raw = apb_stb[1]; end
    else if (SRC == SRC_TMR0) begin : g_s assign raw = tmr_stb[0]; end
    else                      begin : g_s assign raw = tmr_stb[1]; end
    assign per_stb_o[i] = raw & en_w[i];
  end

  assign ahb_stb_o   = ahb_stb;
  assign apb_stb_o   = apb_stb;
  assign tmr_stb_o   = tmr_stb;
  assign per_wdata_o = bus_wdata_i;

endmodule

// File: rtl/clkstb_chk.sv
module clkstb_chk #(
  parameter int NP = 4,
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_wr_i,
  input logic          bus_rd_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          ahb_stb_o,
  input logic [1:0]    apb_stb_o,
  input logic [1:0]    tmr_stb_o,
  input logic [NP-1:0] per_stb_o,
  input logic [NP-1:0] per_wr_o,
  input logic [NP-1:0] per_rd_o,
  input logic [NP-1:0] en_i
);
  for (genvar k = 0; k < 2; k++) begin : g_dom
    p_apb_in_ahb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      apb_stb_o[k] |-> ahb_stb_o);
    p_tmr_on_apb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      apb_stb_o[k] |-> tmr_stb_o[k]);
    p_tmr_in_ahb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_stb_o[k] |-> ahb_stb_o);
  end

  for (genvar i = 0; i < NP; i++) begin : g_per
    p_per_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_stb_o[i] |-> en_i[i]);
    p_wr_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_wr_o[i] |-> (en_i[i] && bus_wr_i));
    p_rd_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_rd_o[i] |-> (en_i[i] && bus_rd_i));
    p_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && (bus_addr_i == AW'(2 + i)) && !en_i[i]) |-> (bus_rdata_o == '0));
  end

  p_en_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (en_i == '0));

endmodule

bind clkstb_gen clkstb_chk #(.NP(NP), .DW(DW), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .ahb_stb_o   (ahb_stb_o),
  .apb_stb_o   (apb_stb_o),
  .tmr_stb_o   (tmr_stb_o),
  .per_stb_o   (per_stb_o),
  .per_wr_o    (per_wr_o),
  .per_rd_o    (per_rd_o),
  .en_i        (en_w)
);

// File: tb/clkstb_gen_tb_top.sv
`timescale 1ns/1ps
module clkstb_gen_tb_top;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int WIN = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic             ahb_stb;
  logic [1:0]       apb_stb, tmr_stb;
  logic [NP-1:0]    per_stb, per_wr, per_rd;
  logic [DW-1:0]    per_wdata;
  logic [NP*DW-1:0] per_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkstb_gen #(.NP(NP), .DW(DW), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ahb_stb_o(ahb_stb), .apb_stb_o(apb_stb), .tmr_stb_o(tmr_stb),
    .per_stb_o(per_stb), .per_wr_o(per_wr), .per_rd_o(per_rd),
    .per_wdata_o(per_wdata), .per_rdata_i(per_rdata));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic int ahb_div(input int code);
    int tbl[8] = '{2, 4, 8, 16, 64, 128, 256, 512};
    return (code < 8) ? 1 : tbl[code-8];
  endfunction
  function automatic int apb_div(input int code);
    return (code < 4) ? 1 : (2 << (code-4));
  endfunction

  int m_ahb_cnt, m_ahb_per, m_ahb_code;
  int m_apb_cnt[2], m_apb_per[2], m_apb_code[2];
  int m_en;
  int p_src[NP] = '{0, 1, 4, 2};

  function automatic bit e_ahb();
    return m_ahb_cnt == m_ahb_per - 1;
  endfunction
  function automatic bit e_apb(input int k);
    return e_ahb() && (m_apb_cnt[k] == m_apb_per[k] - 1);
  endfunction
  function automatic bit e_tmr(input int k);
    return e_ahb() && ((m_apb_cnt[k] == m_apb_per[k] - 1) ||
                       (m_apb_per[k] > 1 && m_apb_cnt[k] == m_apb_per[k]/2 - 1));
  endfunction
  function automatic bit e_per(input int i);
    bit s;
    case (p_src[i])
      0: s = e_ahb();
      1: s = e_apb(0);
      2: s = e_apb(1);
      3: s = e_tmr(0);
      default: s = e_tmr(1);
    endcase
    return s && m_en[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ahb_cnt = 0; m_ahb_per = 1; m_ahb_code = 0; m_en = 0;
      for (int k = 0; k < 2; k++) begin
        m_apb_cnt[k] = 0; m_apb_per[k] = 1; m_apb_code[k] = 0;
      end
    end else begin
      bit a, p0, p1;
      a = e_ahb(); p0 = e_apb(0); p1 = e_apb(1);
      for (int k = 0; k < 2; k++) begin
        if (a) begin
          if ((k == 0) ? p0 : p1) begin
            m_apb_cnt[k] = 0; m_apb_per[k] = apb_div(m_apb_code[k]);
          end else m_apb_cnt[k]++;
        end
      end
      if (a) begin m_ahb_cnt = 0; m_ahb_per = ahb_div(m_ahb_code); end
      else m_ahb_cnt++;
      if (bus_wr && bus_addr == 0) begin
        m_ahb_code = int'(bus_wdata[3:0]);
        m_apb_code[0] = int'(bus_wdata[6:4]);
        m_apb_code[1] = int'(bus_wdata[10:8]);
      end
      if (bus_wr && bus_addr == 1) m_en = int'(bus_wdata[NP-1:0]);
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ahb_stb == e_ahb(), "R1 ahb strobe vs model", ahb_stb, e_ahb());
      for (int k = 0; k < 2; k++) begin
        chk(apb_stb[k] == e_apb(k), "R3 apb strobe vs model", apb_stb[k], e_apb(k));
        chk(tmr_stb[k] == e_tmr(k), "R5 timer strobe vs model", tmr_stb[k], e_tmr(k));
      end
      for (int i = 0; i < NP; i++)
        chk(per_stb[i] == e_per(i), "R7 peripheral strobe vs model", per_stb[i], e_per(i));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int d, output logic [NP-1:0] rds);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    #1;
    d = int'(bus_rdata); rds = per_rd;
    bus_rd = 1'b0;
  endtask

  // sel: -1 main bus, 0/1 peripheral-bus domain
  task automatic wait_stb(input int sel, input int n);
    for (int j = 0; j < n; j++) begin
      do @(negedge clk);
      while (!((sel < 0) ? ahb_stb : apb_stb[sel]));
    end
  endtask

  task automatic count_win(input int k, output int na, output int np, output int nt);
    na = 0; np = 0; nt = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      na += int'(ahb_stb); np += int'(apb_stb[k]); nt += int'(tmr_stb[k]);
    end
  endtask

  task automatic cfg_word(input int a, input int p0, input int p1, output int w);
    w = a | (p0 << 4) | (p1 << 8);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int d, na, np, nt, w, n;
    logic [NP-1:0] rds;

    // R7 / R9 reset state
    repeat (3) @(negedge clk);
    chk(per_stb == '0, "R7 peripheral strobes off in reset", per_stb, 0);
    rd_reg(0, d, rds); chk(d == 0, "R9 cfg reset value", d, 0);
    rd_reg(1, d, rds); chk(d == 0, "R7 enable reset value", d, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: divide-by-1 after reset
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); chk(ahb_stb == 1'b1, "R10 ahb strobe every cycle", ahb_stb, 1);
    end

    // R9 register readback
    cfg_word(9, 5, 6, w); wr_reg(0, w);
    rd_reg(0, d, rds); chk(d == w, "R9 cfg readback", d, w);
    wr_reg(1, 4'b1010);
    rd_reg(1, d, rds); chk(d == 4'b1010, "R9 enable readback", d, 4'b1010);
    wr_reg(1, 0);

    // R8 access gating, peripheral 0 at address 2
    per_rdata = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2; bus_wdata = 16'h5a5a; #1;
    chk(per_wr == '0, "R8 write blocked while disabled", per_wr, 0);
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(2, d, rds);
    chk(d == 0, "R8 disabled read returns zero", d, 0);
    chk(rds == '0, "R8 disabled read not forwarded", rds, 0);
    wr_reg(1, 4'b0001);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2; bus_wdata = 16'h5a5a; #1;
    chk(per_wr == 4'b0001, "R8 write forwarded when enabled", per_wr, 1);
    chk(per_wdata == 16'h5a5a, "R8 write data forwarded", per_wdata, 16'h5a5a);
    @(negedge clk); bus_wr = 1'b0;
    rd_reg(2, d, rds);
    chk(d == 16'h1111, "R8 enabled read data", d, 16'h1111);
    chk(rds == 4'b0001, "R8 enabled read forwarded", rds, 1);
    rd_reg(3, d, rds);
    chk(d == 0, "R8 other disabled peripheral reads zero", d, 0);
    wr_reg(1, 4'b1111);

    // R1 main-bus rate for every code
    for (int code = 0; code < 16; code++) begin
      cfg_word(code, 4, 4, w); wr_reg(0, w);
      wait_stb(-1, 2);
      count_win(0, na, np, nt);
      chk(na == WIN / ahb_div(code), "R1 ahb strobe count per window", na, WIN / ahb_div(code));
    end

    // R6 change applied at next terminal: div16 -> div4
    cfg_word(11, 4, 4, w); wr_reg(0, w);
    wait_stb(-1, 2);
    bus_wr = 1'b1; bus_addr = 0; cfg_word(9, 4, 4, w); bus_wdata = DW'(w);
    n = 0;
    do begin @(negedge clk); n++; if (n == 1) bus_wr = 1'b0; end while (!ahb_stb);
    chk(n == 16, "R6 old period completes after change", n, 16);
    n = 0;
    do begin @(negedge clk); n++; end while (!ahb_stb);
    chk(n == 4, "R6 new period after terminal", n, 4);

    // R2 / R4 / R5 peripheral-bus and timer rates, main bus divided by 2
    for (int k = 0; k < 2; k++) begin
      for (int code = 0; code < 8; code++) begin
        int dv, ep, et;
        cfg_word(8, (k == 0) ? code : 4, (k == 1) ? code : 4, w); wr_reg(0, w);
        wait_stb(k, 3);
        count_win(k, na, np, nt);
        dv = apb_div(code);
        ep = WIN / (2 * dv);
        et = (dv > 1) ? 2 * ep : ep;
        chk(np == ep, "R2 apb strobe count per window", np, ep);
        if (dv == 1) chk(nt == ep, "R4 timer equals apb at divide 1", nt, et);
        else         chk(nt == et, "R5 timer at twice apb rate", nt, et);
        if (dv == 2) chk(nt == na, "R5 timer equals ahb at divide 2", nt, na);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule